// File: doc/BRIEF.md
# Transactor Input Sequencer

This block sits on the hardware side of a co-emulation link, in front of a bus functional model's transaction engine. It raises a ready-for-input request to the software test, takes exactly one input message per request, decodes it and either launches a transaction on the engine, spends one cycle doing nothing, or goes quiet for a counted number of its own clock cycles before asking again. A multi-cycle idle command gives the same cycle timing as the equivalent run of single-cycle no-ops, but needs only one message exchange over the link.

A separate wakeup strobe, the only input accepted without a request, cuts an idle short so that a test waiting on an event of unknown timing can reopen the loop at once. A wakeup that arrives when the block is not idling changes nothing and raises a sticky error flag. Results produced by the engine are passed back to the test one cycle later, with no flow control in that direction.

Top module: `txn_input_sequencer`

## Requirements
- R1: While the reset input is low, and after it rises until the internal synchronised reset releases, the block is in the request state: in_req is 1 and eng_start, out_valid and wakeup_error are 0. Reset assertion takes effect without a clock edge; release is aligned to clk.
- R2: A message is taken only on a clock edge where in_req and in_valid are both 1; in_valid with in_req at 0 has no effect on eng_start, on the idle length or on when in_req rises.
- R3: Opcode encoding on in_opcode: 2'b00 no-op, 2'b01 idle-N, 2'b10 transaction, 2'b11 reserved. An accepted no-op occupies its acceptance cycle only, so in_req is still 1 in the next cycle and no transaction starts.
- R4: An accepted idle-N with N taken from in_payload keeps in_req at 0 for exactly N-1 cycles after the acceptance cycle, then returns it to 1, matching N back-to-back no-ops; N=0 behaves as N=1.
- R5: A wakeup high on an edge while idling ends the idle, and in_req is 1 in the cycle after that edge; a wakeup coinciding with the final idle cycle yields one request, the same as without it.
- R6: A wakeup while requesting or busy is ignored: in_req and any running transaction are unaffected, and wakeup_error goes to 1 on the next cycle and stays 1 until reset.
- R7: An accepted transaction gives a one-cycle eng_start pulse in the next cycle with eng_data equal to the accepted payload; in_req stays 0 until the edge on which eng_done is seen, and is 1 in the following cycle.
- R8: An accepted reserved opcode behaves as a no-op: in_req remains 1 and eng_start stays 0.
- R9: eng_out_valid and eng_out_data appear on out_valid and out_data one cycle later in every state, with no ready signal in the output direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; idle counts are in these cycles |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| in_req | output | 1 | Ready for the next input message |
| in_valid | input | 1 | Message present on in_opcode/in_payload |
| in_opcode | input | 2 | Message kind |
| in_payload | input | PAY_W (16) | Idle count or transaction data |
| wakeup | input | 1 | Out-of-band idle termination strobe |
| eng_start | output | 1 | One-cycle transaction launch to the engine |
| eng_data | output | PAY_W (16) | Transaction data for the engine |
| eng_done | input | 1 | Engine finished the current transaction |
| eng_out_valid | input | 1 | Engine has an output message |
| eng_out_data | input | OUT_W (8) | Engine output message |
| out_valid | output | 1 | Output message to the test |
| out_data | output | OUT_W (8) | Output message contents |
| wakeup_error | output | 1 | Sticky: wakeup seen outside an idle |

## Verification
The properties take for granted that the engine raises eng_done only while a transaction is running and that wakeup is a single-cycle strobe; they do not assume wakeup appears only while idling, since that case is itself checked. The stimulus keeps eng_done low outside a transaction, pulses wakeup for one cycle at a time, and sweeps idle counts, wakeup offsets inside an idle, and engine completion delays over small ranges so every boundary is reached, with misplaced wakeups issued only in the dedicated error phases, each followed by a reset.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [1:0] {
    OP_NOP  = 2'b00,
    OP_IDLE = 2'b01,
    OP_XACT = 2'b10,
    OP_RSVD = 2'b11
  } seq_op_e;

  typedef enum logic [1:0] {
    ST_REQUEST = 2'b00,
    ST_IDLE    = 2'b01,
    ST_BUSY    = 2'b10
  } seq_state_e;

endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else begin
      shift_q <= {shift_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = shift_q[STAGES-1];

endmodule

// File: rtl/seq_idle_cnt.sv
module seq_idle_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] count_in,
  input  logic             dec,
  input  logic             clr,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // Remaining idle cycles after the acceptance cycle: max(N,1)-1
  always_comb begin
    cnt_en = load | dec | clr;
    cnt_d  = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (load) begin
      cnt_d = (count_in == '0) ? '0 : count_in - 1'b1;
    end else if (dec && cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign last = (cnt_q <= {{(CNT_W-1){1'b0}}, 1'b1});

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int PAY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_opcode,
  input  logic [PAY_W-1:0] in_payload,
  input  logic             wakeup,
  input  logic             eng_done,
  input  logic             cnt_last,
  output logic             in_req,
  output logic             cnt_load,
  output logic             cnt_dec,
  output logic             cnt_clr,
  output logic             eng_start,
  output logic [PAY_W-1:0] eng_data,
  output logic             wakeup_error,
  output logic             st_idle,
  output logic             st_busy
);

  seq_state_e state_q, state_d;
  seq_op_e    op;
  logic       take;
  logic       take_xact;
  logic       take_long_idle;
  logic       start_q;
  logic [PAY_W-1:0] data_q;
  logic       err_q, err_d;

  assign op             = seq_op_e'(in_opcode);
  assign take           = (state_q == ST_REQUEST) && in_valid;
  assign take_xact      = take && (op == OP_XACT);
  assign take_long_idle = take && (op == OP_IDLE) &&
                          (in_payload > {{(PAY_W-1){1'b0}}, 1'b1});

  // next-state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_REQUEST: begin
        if (take_xact) begin
          state_d = ST_BUSY;
        end else if (take_long_idle) begin
          state_d = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (wakeup || cnt_last) begin
          state_d = ST_REQUEST;
        end
      end
      ST_BUSY: begin
        if (eng_done) begin
          state_d = ST_REQUEST;
        end
      end
      default: state_d = ST_REQUEST;
    endcase
  end

  always_comb begin
    err_d = err_q | (wakeup && (state_q != ST_IDLE));
  end

  assign cnt_load = take_long_idle;
  assign cnt_dec  = (state_q == ST_IDLE) && !wakeup;
  assign cnt_clr  = (state_q == ST_IDLE) && (wakeup || cnt_last);

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_REQUEST;
      start_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= take_xact;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (take_xact) begin
      data_q <= in_payload;
    end
  end

  assign in_req       = (state_q == ST_REQUEST);
  assign eng_start    = start_q;
  assign eng_data     = data_q;
  assign wakeup_error = err_q;
  assign st_idle      = (state_q == ST_IDLE);
  assign st_busy      = (state_q == ST_BUSY);

endmodule

// File: rtl/seq_out_fwd.sv
module seq_out_fwd #(
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_valid,
  input  logic [OUT_W-1:0] src_data,
  output logic             dst_valid,
  output logic [OUT_W-1:0] dst_data
);

  logic             vld_q;
  logic [OUT_W-1:0] dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= src_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
    end else if (src_valid) begin
      dat_q <= src_data;
    end
  end

  assign dst_valid = vld_q;
  assign dst_data  = dat_q;

endmodule

// File: rtl/txn_input_sequencer.sv
module txn_input_sequencer #(
  parameter int PAY_W       = 16,
  parameter int OUT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             in_req,
  input  logic             in_valid,
  input  logic [1:0]       in_opcode,
  input  logic [PAY_W-1:0] in_payload,
  input  logic             wakeup,
  output logic             eng_start,
  output logic [PAY_W-1:0] eng_data,
  input  logic             eng_done,
  input  logic             eng_out_valid,
  input  logic [OUT_W-1:0] eng_out_data,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data,
  output logic             wakeup_error
);

  logic rst_sync_n;
  logic cnt_load, cnt_dec, cnt_clr, cnt_last;
  logic st_idle, st_busy;

  seq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  seq_idle_cnt #(.CNT_W(PAY_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (cnt_load),
    .count_in (in_payload),
    .dec      (cnt_dec),
    .clr      (cnt_clr),
    .last     (cnt_last)
  );

  seq_ctrl #(.PAY_W(PAY_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .in_valid     (in_valid),
    .in_opcode    (in_opcode),
    .in_payload   (in_payload),
    .wakeup       (wakeup),
    .eng_done     (eng_done),
    .cnt_last     (cnt_last),
    .in_req       (in_req),
    .cnt_load     (cnt_load),
    .cnt_dec      (cnt_dec),
    .cnt_clr      (cnt_clr),
    .eng_start    (eng_start),
    .eng_data     (eng_data),
    .wakeup_error (wakeup_error),
    .st_idle      (st_idle),
    .st_busy      (st_busy)
  );

  seq_out_fwd #(.OUT_W(OUT_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .src_valid (eng_out_valid),
    .src_data  (eng_out_data),
    .dst_valid (out_valid),
    .dst_data  (out_data)
  );

endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int PAY_W = 16,
  parameter int OUT_W = 8
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             in_req,
  input logic             in_valid,
  input logic [1:0]       in_opcode,
  input logic [PAY_W-1:0] in_payload,
  input logic             wakeup,
  input logic             eng_start,
  input logic [PAY_W-1:0] eng_data,
  input logic             eng_done,
  input logic             eng_out_valid,
  input logic [OUT_W-1:0] eng_out_data,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data,
  input logic             wakeup_error,
  input logic             st_idle,
  input logic             st_busy
);

  AST_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(eng_start) |-> $past(in_req && in_valid && in_opcode == 2'b10)); // R2

  AST_SHORT_MSG_KEEPS_REQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_req && in_valid && (in_opcode == 2'b00 || in_opcode == 2'b11 ||
      (in_opcode == 2'b01 && in_payload <= 1))) |=> in_req); // R3

  AST_WAKE_REOPENS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_idle && wakeup) |=> in_req); // R5

  AST_ERR_RAISED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wakeup && !st_idle) |=> wakeup_error); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wakeup_error |=> wakeup_error); // R6

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_busy && !eng_done) |=> (!in_req && st_busy)); // R7

  AST_XACT_LAUNCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_req && in_valid && in_opcode == 2'b10) |=>
      (eng_start && eng_data == $past(in_payload))); // R7

  AST_OUT_FORWARD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    eng_out_valid |=> (out_valid && out_data == $past(eng_out_data))); // R9

  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !eng_out_valid |=> !out_valid); // R9

endmodule

bind txn_input_sequencer seq_checker #(.PAY_W(PAY_W), .OUT_W(OUT_W)) u_chk (
  .clk           (clk),
  .rst_sync_n    (rst_sync_n),
  .in_req        (in_req),
  .in_valid      (in_valid),
  .in_opcode     (in_opcode),
  .in_payload    (in_payload),
  .wakeup        (wakeup),
  .eng_start     (eng_start),
  .eng_data      (eng_data),
  .eng_done      (eng_done),
  .eng_out_valid (eng_out_valid),
  .eng_out_data  (eng_out_data),
  .out_valid     (out_valid),
  .out_data      (out_data),
  .wakeup_error  (wakeup_error),
  .st_idle       (st_idle),
  .st_busy       (st_busy)
);

// File: tb/txn_input_sequencer_tb.sv
`timescale 1ns/1ps
module txn_input_sequencer_tb;

  localparam int PAY_W = 16;
  localparam int OUT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_req;
  logic             in_valid;
  logic [1:0]       in_opcode;
  logic [PAY_W-1:0] in_payload;
  logic             wakeup;
  logic             eng_start;
  logic [PAY_W-1:0] eng_data;
  logic             eng_done;
  logic             eng_out_valid;
  logic [OUT_W-1:0] eng_out_data;
  logic             out_valid;
  logic [OUT_W-1:0] out_data;
  logic             wakeup_error;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  txn_input_sequencer #(.PAY_W(PAY_W), .OUT_W(OUT_W)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_req        (in_req),
    .in_valid      (in_valid),
    .in_opcode     (in_opcode),
    .in_payload    (in_payload),
    .wakeup        (wakeup),
    .eng_start     (eng_start),
    .eng_data      (eng_data),
    .eng_done      (eng_done),
    .eng_out_valid (eng_out_valid),
    .eng_out_data  (eng_out_data),
    .out_valid     (out_valid),
    .out_data      (out_data),
    .wakeup_error  (wakeup_error)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    check("R1 async in_req", {31'b0, in_req}, 32'd1);
    tick();
    tick();
    rst_n = 1'b1;
    check("R1 held in_req", {31'b0, in_req}, 32'd1);
    tick(); tick(); tick();
  endtask

  task automatic send(input logic [1:0] op, input logic [PAY_W-1:0] pay);
    in_valid   = 1'b1;
    in_opcode  = op;
    in_payload = pay;
    tick();
    in_valid   = 1'b0;
  endtask

  // Count cycles with in_req low, bounded
  task automatic count_low(output int c);
    c = 0;
    while (!in_req && c < 200) begin
      c++;
      tick();
    end
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c;
    in_valid = 0; in_opcode = 0; in_payload = 0; wakeup = 0;
    eng_done = 0; eng_out_valid = 0; eng_out_data = 0;

    do_reset();
    // R1: post-reset state
    check("R1 in_req", {31'b0, in_req}, 32'd1);
    check("R1 eng_start", {31'b0, eng_start}, 32'd0);
    check("R1 out_valid", {31'b0, out_valid}, 32'd0);
    check("R1 wakeup_error", {31'b0, wakeup_error}, 32'd0);

    // R3: no-op keeps requesting
    send(2'b00, 16'h1234);
    check("R3 nop in_req", {31'b0, in_req}, 32'd1);
    check("R3 nop eng_start", {31'b0, eng_start}, 32'd0);

    // R8: reserved behaves as no-op
    send(2'b11, 16'h0005);
    check("R8 rsvd in_req", {31'b0, in_req}, 32'd1);
    check("R8 rsvd eng_start", {31'b0, eng_start}, 32'd0);

    // R4: idle-N sweep, low for max(N,1)-1 cycles
    for (int n = 0; n <= 20; n++) begin
      send(2'b01, PAY_W'(n));
      count_low(c);
      check($sformatf("R4 idle N=%0d low", n), c, (n == 0) ? 0 : n - 1);
    end

    // R2: in_valid while not requesting is ignored
    send(2'b01, 16'd6);
    in_valid = 1'b1; in_opcode = 2'b10; in_payload = 16'hBEEF;
    tick();
    in_valid = 1'b0;
    check("R2 no start while idle", {31'b0, eng_start}, 32'd0);
    count_low(c);
    check("R2 idle length kept", c, 32'd5 - 32'd1 + 32'd0);
    check("R2 no start after idle", {31'b0, eng_start}, 32'd0);

    // R5: wakeup at every offset of an idle of 10
    for (int k = 0; k <= 8; k++) begin
      send(2'b01, 16'd10);
      for (int j = 0; j < k; j++) tick();
      check($sformatf("R5 k=%0d still idle", k), {31'b0, in_req}, 32'd0);
      wakeup = 1'b1;
      tick();
      wakeup = 1'b0;
      check($sformatf("R5 k=%0d reopen", k), {31'b0, in_req}, 32'd1);
      check($sformatf("R5 k=%0d no err", k), {31'b0, wakeup_error}, 32'd0);
      // single request: a following idle of 3 behaves normally
      send(2'b01, 16'd3);
      count_low(c);
      check($sformatf("R5 k=%0d next idle", k), c, 32'd2);
    end

    // R7: transactions with completion delays 0..5
    for (int d = 0; d <= 5; d++) begin
      send(2'b10, 16'hA500 + 16'(d));
      check($sformatf("R7 d=%0d start", d), {31'b0, eng_start}, 32'd1);
      check($sformatf("R7 d=%0d data", d), {16'b0, eng_data}, {16'b0, 16'hA500 + 16'(d)});
      check($sformatf("R7 d=%0d req low", d), {31'b0, in_req}, 32'd0);
      for (int i = 0; i < d; i++) begin
        tick();
        check($sformatf("R7 d=%0d busy", d), {30'b0, in_req, eng_start}, 32'd0);
      end
      eng_done = 1'b1;
      tick();
      eng_done = 1'b0;
      check($sformatf("R7 d=%0d back", d), {31'b0, in_req}, 32'd1);
    end

    // R9: output forwarding sweep in request state
    for (int v = 0; v < 256; v++) begin
      eng_out_valid = 1'b1;
      eng_out_data  = OUT_W'(v);
      tick();
      check("R9 fwd", {23'b0, out_valid, out_data}, {23'b0, 1'b1, 8'(v)});
    end
    eng_out_valid = 1'b0;
    tick();
    check("R9 quiet", {31'b0, out_valid}, 32'd0);

    // R9: forwarding while idling and busy
    send(2'b01, 16'd5);
    eng_out_valid = 1'b1; eng_out_data = 8'h3C;
    tick();
    eng_out_valid = 1'b0;
    check("R9 fwd idle", {23'b0, out_valid, out_data}, {23'b0, 1'b1, 8'h3C});
    count_low(c);
    send(2'b10, 16'h0077);
    eng_out_valid = 1'b1; eng_out_data = 8'hC3;
    tick();
    eng_out_valid = 1'b0;
    check("R9 fwd busy", {23'b0, out_valid, out_data}, {23'b0, 1'b1, 8'hC3});
    eng_done = 1'b1; tick(); eng_done = 1'b0;

    // R6: wakeup during a transaction is ignored and flagged
    send(2'b10, 16'h0042);
    wakeup = 1'b1;
    tick();
    wakeup = 1'b0;
    check("R6 busy req stays low", {31'b0, in_req}, 32'd0);
    check("R6 busy err set", {31'b0, wakeup_error}, 32'd1);
    tick();
    check("R6 busy still low", {31'b0, in_req}, 32'd0);
    eng_done = 1'b1; tick(); eng_done = 1'b0;
    check("R6 done after wake", {31'b0, in_req}, 32'd1);
    check("R6 data kept", {16'b0, eng_data}, 32'h0042);
    tick(); tick();
    check("R6 sticky", {31'b0, wakeup_error}, 32'd1);
    do_reset();
    check("R1 err cleared", {31'b0, wakeup_error}, 32'd0);

    // R6: wakeup while requesting is ignored and flagged
    wakeup = 1'b1;
    tick();
    wakeup = 1'b0;
    check("R6 req unchanged", {31'b0, in_req}, 32'd1);
    check("R6 req err set", {31'b0, wakeup_error}, 32'd1);
    send(2'b01, 16'd4);
    count_low(c);
    check("R6 idle after stray wake", c, 32'd3);
    check("R6 sticky after idle", {31'b0, wakeup_error}, 32'd1);
    do_reset();
    check("R1 final reset", {30'b0, in_req, wakeup_error}, 32'd2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule